// File: doc/BRIEF.md
# Shadowed Dual-Port Window Decoder

This block sits on the local bus of one coprocessor that has an 8-bit data path. It decodes each CPU bus cycle into chip selects and write enables for a 512K-byte private SRAM and for the CPU side of a 2K-byte dual-port RAM. The host shares the dual-port RAM. A map input from the host configuration places the dual-port window at one of two bases: low, from $0000 to $07FF, or high, from $7800 to $7FFF.

The window does not hide the SRAM underneath it. Both memories respond together. A write inside the window goes into both arrays, and a read returns the bitwise OR of the two bytes. The decoder acknowledges every local access one cycle after the strobe. It ignores strobes while the CPU is held in reset, and it raises no interrupt.

Top module: `shadow_win_dec`

## Requirements
- R1: With `map_low_i` = 1 at the start of a cycle, addresses $0000 to $07FF assert `dp_cs_o`, and $0800 does not. `dp_addr_o` carries the low 11 address bits.
- R2: With `map_low_i` = 0 at the start of a cycle, addresses $7800 to $7FFF assert `dp_cs_o`, and $77FF and $0000 do not.
- R3: `sram_cs_o` is asserted for every address below $80000, inside or outside the window. `sram_addr_o` carries the low 19 address bits.
- R4: On a read (`rw_i` = 1), `rdata_o` is the bitwise OR of `sram_rdata_i` and `dp_rdata_i` inside the window, and `sram_rdata_i` alone outside it.
- R5: On a write (`rw_i` = 0) inside the window, `sram_we_o` and `dp_we_o` rise together for exactly one clock. Both memories receive the CPU byte on `sram_wdata_o`/`dp_wdata_o`.
- R6: `map_low_i` is sampled only when a bus cycle starts. Changing it during a cycle does not change that cycle's selects.
- R7: `dtack_o` is low in the cycle the strobe first appears. It is high from the next clock edge until the clock after the strobe is released.
- R8: Addresses at or above $80000 assert no chip select and no write enable, and they read $00. They are still acknowledged.
- R9: While `cpu_hold_i` = 1, a strobe starts no cycle. No select, no write enable and no acknowledge appear.
- R10: After a synchronous active-low reset, and one clock after the strobe is released, all selects, write enables and `dtack_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_hold_i | input | 1 | CPU held in reset by host; strobes ignored |
| map_low_i | input | 1 | 1: window at $0000, 0: window at $7800 |
| strobe_i | input | 1 | CPU address/data strobe, active high |
| rw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 24 | CPU byte address |
| wdata_i | input | 8 | CPU write byte |
| rdata_o | output | 8 | Merged read byte to the CPU |
| dtack_o | output | 1 | Data acknowledge to the CPU |
| sram_cs_o | output | 1 | Private SRAM select |
| sram_we_o | output | 1 | Private SRAM write enable |
| sram_addr_o | output | 19 | Private SRAM address |
| sram_wdata_o | output | 8 | Private SRAM write byte |
| sram_rdata_i | input | 8 | Private SRAM read byte |
| dp_cs_o | output | 1 | Dual-port RAM select, CPU side |
| dp_we_o | output | 1 | Dual-port RAM write enable |
| dp_addr_o | output | 11 | Dual-port RAM address |
| dp_wdata_o | output | 8 | Dual-port RAM write byte |
| dp_rdata_i | input | 8 | Dual-port RAM read byte |

## Verification
A wrong latched window flag shows up in the first cycle after the strobe is sampled. `dp_cs_o` is wrong at the boundary addresses $07FF/$0800 and $77FF/$7800, and the read byte then lacks the dual-port bits or includes bits it should not have. Sampling the map at the wrong time makes the selects change in the middle of a cycle, which the bench catches by toggling the map while the strobe is held. A write-enable pulse that is stuck or too long shows on the second clock of a write. A stale cycle flag leaves `dtack_o` high one clock after the strobe is released.

// File: rtl/shadow_win_pkg.sv
// Package: shared types for the shadowed window decoder.
// Assumes a single-master local bus; no bursts.
package shadow_win_pkg;
    // Kind of access latched at the start of a bus cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;
endpackage

// File: rtl/shadow_win_map.sv
// shadow_win_map: combinational address decode.
// Flags whether an address falls in private SRAM, and whether it falls in the
// dual-port window at the base chosen by map_low. Assumes that the window size
// is a power of two and that the high base is aligned to it.
module shadow_win_map #(
    parameter int                CPU_AW  = 24,
    parameter int                SRAM_AW = 19,
    parameter int                DP_AW   = 11,
    parameter logic [CPU_AW-1:0] HI_BASE = 24'h007800
) (
    input  logic [CPU_AW-1:0] addr,
    input  logic              map_low,
    output logic              in_sram,
    output logic              in_win
);
    localparam int              TAGW   = CPU_AW - DP_AW;
    localparam logic [TAGW-1:0] HI_TAG = HI_BASE[CPU_AW-1:DP_AW];

    logic [TAGW-1:0] tag;
    assign tag = addr[CPU_AW-1:DP_AW];

    // Range test for SRAM; any bits above the SRAM width must be zero.
    generate
        if (CPU_AW > SRAM_AW) begin : g_upper
            assign in_sram = (addr[CPU_AW-1:SRAM_AW] == '0);
        end else begin : g_full
            assign in_sram = 1'b1;
        end
    endgenerate

    // Window hit: tag matches either base zero or the high base.
    always_comb begin
        if (map_low) in_win = in_sram && (tag == '0);
        else         in_win = in_sram && (tag == HI_TAG);
    end
endmodule

// File: rtl/shadow_win_seq.sv
// shadow_win_seq: bus-cycle sequencer.
// Latches the decode when a strobe starts a cycle, drives registered selects,
// single-clock write enables and the acknowledge, and clears everything when
// the strobe drops. Assumes the strobe stays high until the acknowledge is seen.
module shadow_win_seq
    import shadow_win_pkg::*;
#(
    parameter int SRAM_AW = 19,
    parameter int DP_AW   = 11,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               strobe,
    input  logic               rw,
    input  logic [SRAM_AW-1:0] addr_lo,
    input  logic [DW-1:0]      wdata,
    input  logic               in_sram,
    input  logic               in_win,
    output acc_e               acc,
    output logic               dtack,
    output logic               sram_cs,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               dp_cs,
    output logic               dp_we,
    output logic [DP_AW-1:0]   dp_addr,
    output logic [DW-1:0]      wdata_q
);
    logic start;
    assign start = strobe && (acc == ACC_IDLE) && !hold;

    // Cycle state: start latches decode, release clears, mid-cycle drops write enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= ACC_IDLE;
            dtack     <= 1'b0;
            sram_cs   <= 1'b0;
            sram_we   <= 1'b0;
            dp_cs     <= 1'b0;
            dp_we     <= 1'b0;
            sram_addr <= '0;
            dp_addr   <= '0;
            wdata_q   <= '0;
        end else if (start) begin
            acc       <= rw ? ACC_READ : ACC_WRITE;
            dtack     <= 1'b1;
            sram_cs   <= in_sram;
            sram_we   <= in_sram && !rw;
            dp_cs     <= in_win;
            dp_we     <= in_win && !rw;
            sram_addr <= addr_lo;
            dp_addr   <= addr_lo[DP_AW-1:0];
            wdata_q   <= wdata;
        end else if (!strobe) begin
            acc     <= ACC_IDLE;
            dtack   <= 1'b0;
            sram_cs <= 1'b0;
            sram_we <= 1'b0;
            dp_cs   <= 1'b0;
            dp_we   <= 1'b0;
        end else begin
            sram_we <= 1'b0;
            dp_we   <= 1'b0;
        end
    end
endmodule

// File: rtl/shadow_win_merge.sv
// shadow_win_merge: read data merge.
// ORs the bytes of whichever memories are selected during a read cycle.
// Assumes that unselected memories may present any value.
module shadow_win_merge
    import shadow_win_pkg::*;
#(
    parameter int DW = 8
) (
    input  acc_e          acc,
    input  logic          sram_cs,
    input  logic          dp_cs,
    input  logic [DW-1:0] sram_rdata,
    input  logic [DW-1:0] dp_rdata,
    output logic [DW-1:0] rdata
);
    // Gate each source by its select and OR them together.
    always_comb begin
        rdata = '0;
        if (acc == ACC_READ) begin
            if (sram_cs) rdata = rdata | sram_rdata;
            if (dp_cs)   rdata = rdata | dp_rdata;
        end
    end
endmodule

// File: rtl/shadow_win_dec.sv
// shadow_win_dec: top of the per-CPU shadowed window decoder.
// SRAM always responds inside its range; the dual-port window overlays it at a
// base chosen by map_low_i, sampled when a cycle starts. Write data goes to both
// memories; read data is their OR. Zero wait states; no interrupts.
module shadow_win_dec #(
    parameter int                CPU_AW  = 24,
    parameter int                SRAM_AW = 19,
    parameter int                DP_AW   = 11,
    parameter int                DW      = 8,
    parameter logic [CPU_AW-1:0] HI_BASE = 24'h007800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_hold_i,
    input  logic               map_low_i,
    input  logic               strobe_i,
    input  logic               rw_i,
    input  logic [CPU_AW-1:0]  addr_i,
    input  logic [DW-1:0]      wdata_i,
    output logic [DW-1:0]      rdata_o,
    output logic               dtack_o,
    output logic               sram_cs_o,
    output logic               sram_we_o,
    output logic [SRAM_AW-1:0] sram_addr_o,
    output logic [DW-1:0]      sram_wdata_o,
    input  logic [DW-1:0]      sram_rdata_i,
    output logic               dp_cs_o,
    output logic               dp_we_o,
    output logic [DP_AW-1:0]   dp_addr_o,
    output logic [DW-1:0]      dp_wdata_o,
    input  logic [DW-1:0]      dp_rdata_i
);
    import shadow_win_pkg::*;

    logic          in_sram;
    logic          in_win;
    acc_e          acc;
    logic [DW-1:0] wdata_q;

    shadow_win_map #(
        .CPU_AW (CPU_AW),
        .SRAM_AW(SRAM_AW),
        .DP_AW  (DP_AW),
        .HI_BASE(HI_BASE)
    ) u_map (
        .addr   (addr_i),
        .map_low(map_low_i),
        .in_sram(in_sram),
        .in_win (in_win)
    );

    shadow_win_seq #(
        .SRAM_AW(SRAM_AW),
        .DP_AW  (DP_AW),
        .DW     (DW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cpu_hold_i),
        .strobe   (strobe_i),
        .rw       (rw_i),
        .addr_lo  (addr_i[SRAM_AW-1:0]),
        .wdata    (wdata_i),
        .in_sram  (in_sram),
        .in_win   (in_win),
        .acc      (acc),
        .dtack    (dtack_o),
        .sram_cs  (sram_cs_o),
        .sram_we  (sram_we_o),
        .sram_addr(sram_addr_o),
        .dp_cs    (dp_cs_o),
        .dp_we    (dp_we_o),
        .dp_addr  (dp_addr_o),
        .wdata_q  (wdata_q)
    );

    shadow_win_merge #(
        .DW(DW)
    ) u_merge (
        .acc       (acc),
        .sram_cs   (sram_cs_o),
        .dp_cs     (dp_cs_o),
        .sram_rdata(sram_rdata_i),
        .dp_rdata  (dp_rdata_i),
        .rdata     (rdata_o)
    );

    // One write byte feeds both memories so shadowed writes stay identical.
    assign sram_wdata_o = wdata_q;
    assign dp_wdata_o   = wdata_q;
endmodule

// File: rtl/shadow_win_dec_chk.sv
// shadow_win_dec_chk: port-level properties of the shadowed window decoder.
// Attached to every shadow_win_dec instance by the bind below.
module shadow_win_dec_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_hold_i,
    input logic          strobe_i,
    input logic          dtack_o,
    input logic          sram_cs_o,
    input logic          sram_we_o,
    input logic          dp_cs_o,
    input logic          dp_we_o,
    input logic [DW-1:0] rdata_o
);
    AST_WIN_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
        dp_cs_o |-> sram_cs_o); // R3
    AST_WE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        dp_we_o |-> sram_we_o); // R5
    AST_WE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_o |=> !sram_we_o); // R5
    AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_cs_o && strobe_i) |=> dp_cs_o); // R6
    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> $past(strobe_i)); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs_o |-> (rdata_o == '0)); // R8
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hold_i && !dtack_o) |=> !dtack_o); // R9
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> (!dtack_o && !sram_cs_o && !dp_cs_o)); // R10
endmodule

bind shadow_win_dec shadow_win_dec_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_hold_i(cpu_hold_i),
    .strobe_i  (strobe_i),
    .dtack_o   (dtack_o),
    .sram_cs_o (sram_cs_o),
    .sram_we_o (sram_we_o),
    .dp_cs_o   (dp_cs_o),
    .dp_we_o   (dp_we_o),
    .rdata_o   (rdata_o)
);

// File: tb/shadow_win_dec_bench.sv
// Directed bench for shadow_win_dec: one task per scenario, each checking itself.
module shadow_win_dec_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_hold_i;
    logic        map_low_i;
    logic        strobe_i;
    logic        rw_i;
    logic [23:0] addr_i;
    logic [7:0]  wdata_i;
    logic [7:0]  rdata_o;
    logic        dtack_o;
    logic        sram_cs_o;
    logic        sram_we_o;
    logic [18:0] sram_addr_o;
    logic [7:0]  sram_wdata_o;
    logic [7:0]  sram_rdata_i;
    logic        dp_cs_o;
    logic        dp_we_o;
    logic [10:0] dp_addr_o;
    logic [7:0]  dp_wdata_o;
    logic [7:0]  dp_rdata_i;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_win_dec u_shadow_win_dec (
        .clk(clk), .rst_n(rst_n), .cpu_hold_i(cpu_hold_i), .map_low_i(map_low_i),
        .strobe_i(strobe_i), .rw_i(rw_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .dtack_o(dtack_o), .sram_cs_o(sram_cs_o),
        .sram_we_o(sram_we_o), .sram_addr_o(sram_addr_o), .sram_wdata_o(sram_wdata_o),
        .sram_rdata_i(sram_rdata_i), .dp_cs_o(dp_cs_o), .dp_we_o(dp_we_o),
        .dp_addr_o(dp_addr_o), .dp_wdata_o(dp_wdata_o), .dp_rdata_i(dp_rdata_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive a strobe at a falling edge; return at the falling edge after the latch.
    task automatic begin_cycle(input logic [23:0] a, input logic rd,
                               input logic [7:0] wd, input logic ml);
        @(negedge clk);
        addr_i = a; rw_i = rd; wdata_i = wd; map_low_i = ml; strobe_i = 1'b1;
        @(negedge clk);
    endtask

    // Release the strobe; return at the falling edge after the clearing edge.
    task automatic end_cycle();
        strobe_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(!dtack_o && !sram_cs_o && !dp_cs_o && !sram_we_o && !dp_we_o,
              "R10 reset", {dtack_o, sram_cs_o, dp_cs_o, sram_we_o, dp_we_o}, 0);
    endtask

    task automatic t_map_low();
        begin_cycle(24'h0007FF, 1'b1, 8'h00, 1'b1);
        check(dp_cs_o && sram_cs_o, "R1 hit 7FF", {dp_cs_o, sram_cs_o}, 3);
        check(dp_addr_o == 11'h7FF, "R1 dp_addr", dp_addr_o, 11'h7FF);
        end_cycle();
        begin_cycle(24'h000800, 1'b1, 8'h00, 1'b1);
        check(!dp_cs_o && sram_cs_o, "R1 miss 800", {dp_cs_o, sram_cs_o}, 1);
        end_cycle();
    endtask

    task automatic t_map_high();
        begin_cycle(24'h007800, 1'b1, 8'h00, 1'b0);
        check(dp_cs_o, "R2 hit 7800", dp_cs_o, 1);
        end_cycle();
        begin_cycle(24'h007FFF, 1'b1, 8'h00, 1'b0);
        check(dp_cs_o && dp_addr_o == 11'h7FF, "R2 hit 7FFF", dp_addr_o, 11'h7FF);
        end_cycle();
        begin_cycle(24'h0077FF, 1'b1, 8'h00, 1'b0);
        check(!dp_cs_o, "R2 miss 77FF", dp_cs_o, 0);
        end_cycle();
        begin_cycle(24'h000000, 1'b1, 8'h00, 1'b0);
        check(!dp_cs_o, "R2 miss 0", dp_cs_o, 0);
        end_cycle();
    endtask

    task automatic t_sram_range();
        begin_cycle(24'h07FFFF, 1'b1, 8'h00, 1'b1);
        check(sram_cs_o && sram_addr_o == 19'h7FFFF, "R3 top of SRAM", sram_addr_o, 19'h7FFFF);
        end_cycle();
        begin_cycle(24'h000123, 1'b1, 8'h00, 1'b1);
        check(sram_cs_o && sram_addr_o == 19'h00123, "R3 inside window", sram_addr_o, 19'h123);
        end_cycle();
    endtask

    task automatic t_read_merge();
        sram_rdata_i = 8'h0F; dp_rdata_i = 8'h31;
        begin_cycle(24'h000010, 1'b1, 8'h00, 1'b1);
        check(rdata_o == 8'h3F, "R4 OR in window", rdata_o, 8'h3F);
        end_cycle();
        begin_cycle(24'h001000, 1'b1, 8'h00, 1'b1);
        check(rdata_o == 8'h0F, "R4 SRAM only outside", rdata_o, 8'h0F);
        end_cycle();
    endtask

    task automatic t_write_both();
        begin_cycle(24'h007A55, 1'b0, 8'hC3, 1'b0);
        check(sram_we_o && dp_we_o, "R5 both we", {sram_we_o, dp_we_o}, 3);
        check(sram_wdata_o == 8'hC3 && dp_wdata_o == 8'hC3, "R5 wdata", dp_wdata_o, 8'hC3);
        @(negedge clk);
        check(!sram_we_o && !dp_we_o, "R5 one clock", {sram_we_o, dp_we_o}, 0);
        end_cycle();
        begin_cycle(24'h002000, 1'b0, 8'h11, 1'b0);
        check(sram_we_o && !dp_we_o, "R5 SRAM-only write", {sram_we_o, dp_we_o}, 2);
        end_cycle();
    endtask

    task automatic t_map_midcycle();
        begin_cycle(24'h000040, 1'b1, 8'h00, 1'b1);
        map_low_i = 1'b0;
        @(negedge clk);
        check(dp_cs_o, "R6 map change mid-cycle", dp_cs_o, 1);
        end_cycle();
    endtask

    task automatic t_ack_timing();
        @(negedge clk);
        addr_i = 24'h000100; rw_i = 1'b1; map_low_i = 1'b1; strobe_i = 1'b1;
        #1;
        check(!dtack_o, "R7 no ack before edge", dtack_o, 0);
        @(negedge clk);
        check(dtack_o, "R7 ack after one clock", dtack_o, 1);
        @(negedge clk);
        check(dtack_o, "R7 ack held", dtack_o, 1);
        end_cycle();
        check(!dtack_o, "R10 ack clears", dtack_o, 0);
    endtask

    task automatic t_unmapped();
        sram_rdata_i = 8'hAA; dp_rdata_i = 8'h55;
        begin_cycle(24'h080000, 1'b0, 8'hFF, 1'b1);
        check(!sram_cs_o && !sram_we_o && !dp_cs_o && !dp_we_o, "R8 no select on write",
              {sram_cs_o, sram_we_o, dp_cs_o, dp_we_o}, 0);
        check(dtack_o, "R8 still acked", dtack_o, 1);
        end_cycle();
        begin_cycle(24'hFF7800, 1'b1, 8'h00, 1'b0);
        check(rdata_o == 8'h00, "R8 reads zero", rdata_o, 0);
        end_cycle();
    endtask

    task automatic t_hold();
        cpu_hold_i = 1'b1;
        begin_cycle(24'h000000, 1'b0, 8'h77, 1'b1);
        @(negedge clk);
        check(!dtack_o && !sram_cs_o && !sram_we_o && !dp_we_o, "R9 held",
              {dtack_o, sram_cs_o, sram_we_o, dp_we_o}, 0);
        end_cycle();
        cpu_hold_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_hold_i = 1'b0; map_low_i = 1'b1; strobe_i = 1'b0;
        rw_i = 1'b1; addr_i = '0; wdata_i = '0; sram_rdata_i = '0; dp_rdata_i = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_map_low();
        t_map_high();
        t_sram_range();
        t_read_merge();
        t_write_both();
        t_map_midcycle();
        t_ack_timing();
        t_unmapped();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule